// File: doc/BRIEF.md
# Tuning Pattern Response Checker

During sample-point calibration of a storage card interface, the host reads one fixed tuning block from the card at each candidate sampling phase. This block watches that read as it streams in, one byte per valid cycle, and compares each byte on the fly with a reference pattern held in constant logic. When the read ends, it gives a one-cycle completion pulse with a pass or fail verdict. A phase sweep controller can then record the phase as usable or unusable without buffering the data.

Two reference patterns are built in. A 64-byte pattern is the default. A 128-byte pattern is used for the wide-bus high-speed tuning command. The pattern is chosen on the first byte of each block. The verdict also takes in command and data error indications. Any error, any differing byte, or a block of the wrong length gives a fail.

Top module: `tune_resp_chk`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `chk_done`, `chk_pass` and `chk_fail` are all 0.
- R2: The short pattern has 64 bytes. It is formed from 16 32-bit words, first word 0x00FF0FFF and last word 0xDE7B7FF7. Each word is sent least significant byte first, so the first bytes expected are 0xFF, 0x0F, 0xFF, 0x00.
- R3: The long pattern has 128 bytes, formed from 32 words, first word 0xFF00FFFF and last word 0xEEDDBB77, with the same byte order. It is used only when `op_hs200` is 1 and `bus_width` is 2'b10 on the first byte of a block. Every other combination selects the short pattern.
- R4: A block whose bytes all match and whose last byte is at index pattern length minus one, with no error, passes. Any byte that differs from the reference makes the block fail.
- R5: A block that ends before the pattern length, or that carries bytes beyond it, fails.
- R6: An asserted `cmd_err` or `dat_err`, whether the checker is idle or inside a block, gives a fail. The remaining bytes of that block, up to and including its last byte, are discarded with no further completion pulse. Errors seen while discarding have no effect.
- R7: `chk_done` is high for exactly one cycle: the cycle after a final byte (`rx_valid` and `rx_last`) or after an error that R6 counts. It is high at no other time.
- R8: `chk_pass` and `chk_fail` are never both 1. They hold the latest verdict until the first byte of the next block, and from the following cycle both are 0 until that block completes.
- R9: An error in the same cycle as a block's final byte gives exactly one completion pulse, with a fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received tuning byte |
| rx_last | input | 1 | With `rx_valid`, marks the final byte of the block |
| cmd_err | input | 1 | Command phase reported an error |
| dat_err | input | 1 | Data phase reported an error |
| op_hs200 | input | 1 | 1 = tuning command is the high-speed variant |
| bus_width | input | 2 | Bus width code; 2'b10 = 8 bits wide |
| chk_pass | output | 1 | Verdict: the block matched |
| chk_fail | output | 1 | Verdict: the block failed |
| chk_done | output | 1 | One-cycle completion pulse |

## Verification
Two things can happen in the same cycle: an error and the final byte of a block. They can meet either on a multi-byte block or on a single-byte block, where the error also lands on the first byte. The random mix places the error index at every position, including the last, and sometimes raises a second error while bytes are being discarded. The check follows `chk_done` cycle by cycle. It passes only with a single pulse carrying a fail, with no second pulse when the block's real last byte arrives, and with the checker idle afterwards so the next clean block passes.

// File: rtl/tune_pkg.sv
// Package: shared constants, state type and the two reference patterns.
// Assumes byte-wide data and patterns whose lengths are multiples of 4.
package tune_pkg;

    localparam int BYTE_W      = 8;
    localparam int WORD_W      = 32;
    localparam int LANES       = WORD_W / BYTE_W;
    localparam int SHORT_WORDS = 16;
    localparam int LONG_WORDS  = 32;
    localparam int SHORT_LEN   = SHORT_WORDS * LANES;
    localparam int LONG_LEN    = LONG_WORDS * LANES;
    localparam int CNT_W       = $clog2(LONG_LEN + 1);
    localparam int WIDX_W      = $clog2(LONG_WORDS);
    localparam int LANE_W      = $clog2(LANES);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_DRAIN = 2'd2
    } seq_st_t;

    // Word of the 64-byte reference pattern
    function automatic logic [WORD_W-1:0] short_word(input logic [WIDX_W-1:0] w);
        logic [WORD_W-1:0] v;
        case (w)
            5'd0:  v = 32'h00FF0FFF;
            5'd1:  v = 32'hCCC3CCFF;
            5'd2:  v = 32'hFFCC3CC3;
            5'd3:  v = 32'hEFFEFFFE;
            5'd4:  v = 32'hDDFFDFFF;
            5'd5:  v = 32'hFBFFFBFF;
            5'd6:  v = 32'hFF7FFFBF;
            5'd7:  v = 32'hEFBDF777;
            5'd8:  v = 32'hF0FFF0FF;
            5'd9:  v = 32'h3CCCFC0F;
            5'd10: v = 32'hCFCC33CC;
            5'd11: v = 32'hEEFFEFFF;
            5'd12: v = 32'hFDFFFDFF;
            5'd13: v = 32'hFFBFFFDF;
            5'd14: v = 32'hFFF7FFBB;
            5'd15: v = 32'hDE7B7FF7;
            default: v = '0;
        endcase
        return v;
    endfunction

    // Word of the 128-byte reference pattern
    function automatic logic [WORD_W-1:0] long_word(input logic [WIDX_W-1:0] w);
        logic [WORD_W-1:0] v;
        case (w)
            5'd0:  v = 32'hFF00FFFF;
            5'd1:  v = 32'h0000FFFF;
            5'd2:  v = 32'hCCCCFFFF;
            5'd3:  v = 32'hCCCC33CC;
            5'd4:  v = 32'hCC3333CC;
            5'd5:  v = 32'hFFFFCCCC;
            5'd6:  v = 32'hFFFFEEFF;
            5'd7:  v = 32'hFFEEEEFF;
            5'd8:  v = 32'hFFDDFFFF;
            5'd9:  v = 32'hDDDDFFFF;
            5'd10: v = 32'hBBFFFFFF;
            5'd11: v = 32'hBBFFFFFF;
            5'd12: v = 32'hFFFFFFBB;
            5'd13: v = 32'hFFFFFF77;
            5'd14: v = 32'h77FF7777;
            5'd15: v = 32'hFFEEDDBB;
            5'd16: v = 32'h00FFFFFF;
            5'd17: v = 32'h00FFFFFF;
            5'd18: v = 32'hCCFFFF00;
            5'd19: v = 32'hCC33CCCC;
            5'd20: v = 32'h3333CCCC;
            5'd21: v = 32'hFFCCCCCC;
            5'd22: v = 32'hFFEEFFFF;
            5'd23: v = 32'hEEEEFFFF;
            5'd24: v = 32'hDDFFFFFF;
            5'd25: v = 32'hDDFFFFFF;
            5'd26: v = 32'hFFFFFFDD;
            5'd27: v = 32'hFFFFFFBB;
            5'd28: v = 32'hFFFFBBBB;
            5'd29: v = 32'hFFFF77FF;
            5'd30: v = 32'hFF7777FF;
            5'd31: v = 32'hEEDDBB77;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tune_ref_rom.sv
// Reference byte lookup: returns the expected byte for a byte index in
// the selected pattern. Assumes the index stays below LONG_LEN when it is
// used; indices at or beyond the pattern end are flagged by the caller.
module tune_ref_rom
    import tune_pkg::*;
#(
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic              sel_long,
    input  logic [CNT_W-1:0]  byte_idx,
    output logic [BYTE_W-1:0] exp_byte
);

    logic [WIDX_W-1:0] word_idx;
    logic [LANE_W-1:0] lane_raw;
    logic [LANE_W-1:0] lane;
    logic [WORD_W-1:0] ref_word;

    // Split the byte index into word and lane
    always_comb begin
        word_idx = byte_idx[LANE_W +: WIDX_W];
        lane_raw = byte_idx[LANE_W-1:0];
    end

    // Lane order is picked by parameter
    generate
        if (LSB_FIRST) begin : g_lsb
            assign lane = lane_raw;
        end else begin : g_msb
            assign lane = LANE_W'(LANES - 1) - lane_raw;
        end
    endgenerate

    // Fetch the word from the selected pattern
    always_comb begin
        if (byte_idx[CNT_W-1])
            ref_word = '0;
        else if (sel_long)
            ref_word = long_word(word_idx);
        else
            ref_word = short_word(word_idx);
    end

    // Extract the lane byte
    always_comb exp_byte = ref_word[lane*BYTE_W +: BYTE_W];

endmodule

// File: rtl/tune_blk_seq.sv
// Block sequencer: tracks idle / receiving / discarding, the current
// byte index (saturating) and the pattern chosen on the first byte.
// Assumes rx_last is only meaningful together with rx_valid.
module tune_blk_seq
    import tune_pkg::*;
#(
    parameter logic [1:0] WIDE_BUS_CODE = 2'b10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_last,
    input  logic             cmd_err,
    input  logic             dat_err,
    input  logic             op_hs200,
    input  logic [1:0]       bus_width,
    output logic             blk_start,
    output logic             byte_take,
    output logic             last_evt,
    output logic             err_evt,
    output logic             sel_long,
    output logic [CNT_W-1:0] byte_idx
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LONG_LEN);

    seq_st_t          st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             sel_q;
    logic             live_long;

    // Decode the events of this cycle
    always_comb begin
        live_long = op_hs200 && (bus_width == WIDE_BUS_CODE);
        blk_start = (st_q == ST_IDLE) && rx_valid;
        byte_take = rx_valid && (st_q != ST_DRAIN);
        last_evt  = byte_take && rx_last;
        err_evt   = (cmd_err || dat_err) && (st_q != ST_DRAIN);
        byte_idx  = blk_start ? '0 : cnt_q;
        sel_long  = blk_start ? live_long : sel_q;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (err_evt) begin
            if (((st_q == ST_RECV) || rx_valid) && !(rx_valid && rx_last))
                st_d = ST_DRAIN;
            else
                st_d = ST_IDLE;
        end else if (last_evt) begin
            st_d = ST_IDLE;
        end else if (blk_start) begin
            st_d = ST_RECV;
        end else if ((st_q == ST_DRAIN) && rx_valid && rx_last) begin
            st_d = ST_IDLE;
        end
    end

    // State, index counter and pattern select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            sel_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (byte_take)
                cnt_q <= (byte_idx == CNT_SAT) ? byte_idx : byte_idx + 1'b1;
            if (blk_start)
                sel_q <= live_long;
        end
    end

endmodule

// File: rtl/tune_verdict.sv
// Verdict logic: accumulates a sticky mismatch over a block and, on the
// final byte or an error, registers the pass/fail verdict and a done pulse.
// Assumes event strobes come from tune_blk_seq in the same cycle as the byte.
module tune_verdict
    import tune_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_start,
    input  logic              byte_take,
    input  logic              last_evt,
    input  logic              err_evt,
    input  logic              sel_long,
    input  logic [CNT_W-1:0]  byte_idx,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic [BYTE_W-1:0] exp_byte,
    output logic              chk_pass,
    output logic              chk_fail,
    output logic              chk_done
);

    logic [CNT_W-1:0] exp_len;
    logic             mm_q;
    logic             mm_prior;
    logic             byte_bad;
    logic             len_bad;
    logic             finish;
    logic             verdict_fail;

    // Combine this cycle's evidence into a verdict
    always_comb begin
        exp_len      = sel_long ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
        mm_prior     = blk_start ? 1'b0 : mm_q;
        byte_bad     = byte_take && ((byte_idx >= exp_len) || (rx_data != exp_byte));
        len_bad      = byte_idx != (exp_len - 1'b1);
        finish       = last_evt || err_evt;
        verdict_fail = err_evt || mm_prior || byte_bad || len_bad;
    end

    // Sticky mismatch, verdict and done pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mm_q     <= 1'b0;
            chk_pass <= 1'b0;
            chk_fail <= 1'b0;
            chk_done <= 1'b0;
        end else begin
            chk_done <= finish;
            if (byte_take)
                mm_q <= mm_prior || byte_bad;
            if (finish) begin
                chk_pass <= !verdict_fail;
                chk_fail <= verdict_fail;
            end else if (blk_start) begin
                chk_pass <= 1'b0;
                chk_fail <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tune_resp_chk.sv
// Top: tuning pattern response checker. Streams received bytes against
// a built-in reference pattern chosen per block and reports a verdict.
// Assumes one byte per valid cycle and rst_n synchronous to clk.
module tune_resp_chk
    import tune_pkg::*;
#(
    parameter logic [1:0] WIDE_BUS_CODE = 2'b10,
    parameter bit         LSB_FIRST     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_last,
    input  logic              cmd_err,
    input  logic              dat_err,
    input  logic              op_hs200,
    input  logic [1:0]        bus_width,
    output logic              chk_pass,
    output logic              chk_fail,
    output logic              chk_done
);

    logic             blk_start;
    logic             byte_take;
    logic             last_evt;
    logic             err_evt;
    logic             sel_long;
    logic [CNT_W-1:0] byte_idx;
    logic [BYTE_W-1:0] exp_byte;

    tune_blk_seq #(.WIDE_BUS_CODE(WIDE_BUS_CODE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_last   (rx_last),
        .cmd_err   (cmd_err),
        .dat_err   (dat_err),
        .op_hs200  (op_hs200),
        .bus_width (bus_width),
        .blk_start (blk_start),
        .byte_take (byte_take),
        .last_evt  (last_evt),
        .err_evt   (err_evt),
        .sel_long  (sel_long),
        .byte_idx  (byte_idx)
    );

    tune_ref_rom #(.LSB_FIRST(LSB_FIRST)) u_rom (
        .sel_long (sel_long),
        .byte_idx (byte_idx),
        .exp_byte (exp_byte)
    );

    tune_verdict u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_start (blk_start),
        .byte_take (byte_take),
        .last_evt  (last_evt),
        .err_evt   (err_evt),
        .sel_long  (sel_long),
        .byte_idx  (byte_idx),
        .rx_data   (rx_data),
        .exp_byte  (exp_byte),
        .chk_pass  (chk_pass),
        .chk_fail  (chk_fail),
        .chk_done  (chk_done)
    );

endmodule

// File: rtl/tune_resp_chk_sva.sv
// Checker: port-level properties of tune_resp_chk, bound to every instance.
// Assumes the synchronous active-low reset is applied from time zero.
module tune_resp_chk_sva (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_last,
    input logic cmd_err,
    input logic dat_err,
    input logic chk_pass,
    input logic chk_fail,
    input logic chk_done
);

    // R8: verdict outputs are exclusive
    assert_verdict_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_pass && chk_fail));

    // R7: done only follows a final byte or an error
    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> $past((rx_valid && rx_last) || cmd_err || dat_err));

    // R8: a completion always carries exactly one verdict
    assert_done_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> (chk_pass != chk_fail));

    // R6: completion caused by an error reports fail
    assert_err_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done && $past(cmd_err || dat_err)) |-> chk_fail);

    // R8: with no byte and no error, the verdict holds
    assert_verdict_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rx_valid) && !$past(cmd_err || dat_err)) |-> ($stable(chk_pass) && $stable(chk_fail)));

    // R1: all outputs low during reset and the cycle after
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!chk_done && !chk_pass && !chk_fail));

endmodule

bind tune_resp_chk tune_resp_chk_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_last  (rx_last),
    .cmd_err  (cmd_err),
    .dat_err  (dat_err),
    .chk_pass (chk_pass),
    .chk_fail (chk_fail),
    .chk_done (chk_done)
);

// File: tb/tb_tune_resp_chk.sv
module tb_tune_resp_chk;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_last = 1'b0;
    logic       cmd_err = 1'b0;
    logic       dat_err = 1'b0;
    logic       op_hs200 = 1'b0;
    logic [1:0] bus_width = 2'b00;
    logic       chk_pass, chk_fail, chk_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tune_resp_chk dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .cmd_err(cmd_err), .dat_err(dat_err),
        .op_hs200(op_hs200), .bus_width(bus_width),
        .chk_pass(chk_pass), .chk_fail(chk_fail), .chk_done(chk_done)
    );

    function automatic logic [31:0] tb_word(input bit lng, input int w);
        logic [31:0] s [16];
        logic [31:0] l [32];
        s = '{32'h00FF0FFF, 32'hCCC3CCFF, 32'hFFCC3CC3, 32'hEFFEFFFE,
              32'hDDFFDFFF, 32'hFBFFFBFF, 32'hFF7FFFBF, 32'hEFBDF777,
              32'hF0FFF0FF, 32'h3CCCFC0F, 32'hCFCC33CC, 32'hEEFFEFFF,
              32'hFDFFFDFF, 32'hFFBFFFDF, 32'hFFF7FFBB, 32'hDE7B7FF7};
        l = '{32'hFF00FFFF, 32'h0000FFFF, 32'hCCCCFFFF, 32'hCCCC33CC,
              32'hCC3333CC, 32'hFFFFCCCC, 32'hFFFFEEFF, 32'hFFEEEEFF,
              32'hFFDDFFFF, 32'hDDDDFFFF, 32'hBBFFFFFF, 32'hBBFFFFFF,
              32'hFFFFFFBB, 32'hFFFFFF77, 32'h77FF7777, 32'hFFEEDDBB,
              32'h00FFFFFF, 32'h00FFFFFF, 32'hCCFFFF00, 32'hCC33CCCC,
              32'h3333CCCC, 32'hFFCCCCCC, 32'hFFEEFFFF, 32'hEEEEFFFF,
              32'hDDFFFFFF, 32'hDDFFFFFF, 32'hFFFFFFDD, 32'hFFFFFFBB,
              32'hFFFFBBBB, 32'hFFFF77FF, 32'hFF7777FF, 32'hEEDDBB77};
        return lng ? l[w] : s[w];
    endfunction

    // Expected byte: LSB first unless swap asks for the wrong order
    function automatic logic [7:0] tb_byte(input bit lng, input int i, input bit swap);
        logic [31:0] w;
        int lane;
        w = tb_word(lng, i / 4);
        lane = swap ? 3 - (i % 4) : i % 4;
        return w[lane*8 +: 8];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one block; err_idx/drain_err_idx < 0 mean none
    task automatic run_block(input bit hs, input logic [1:0] bw, input int n_bytes,
                             input int bad_idx, input int err_idx, input bit use_cmd,
                             input int drain_err_idx, input bit swap, input string req);
        bit lng;
        int plen;
        bit exp_fail;
        bit exp_d;
        bit seen_err;
        lng = hs && (bw == 2'b10);
        plen = lng ? 128 : 64;
        exp_fail = (n_bytes != plen) || (bad_idx >= 0 && bad_idx < n_bytes) ||
                   (err_idx >= 0 && err_idx < n_bytes) || swap;
        exp_d = 1'b0;
        seen_err = 1'b0;
        op_hs200 = hs;
        bus_width = bw;
        for (int i = 0; i < n_bytes; i++) begin
            @(negedge clk);
            check(chk_done == exp_d, {req, " done timing R7"}, chk_done, exp_d);
            if (exp_d)
                check(chk_fail == exp_fail && chk_pass == !exp_fail, {req, " verdict"}, chk_fail, exp_fail);
            else if (i == 1)
                check(!chk_pass && !chk_fail, "R8 verdict cleared at block start", {chk_pass, chk_fail}, 0);
            rx_valid = 1'b1;
            rx_data = (i < plen) ? tb_byte(lng, i, swap) : 8'($urandom);
            if (i == bad_idx)
                rx_data = rx_data ^ (8'h01 << ($urandom % 8));
            rx_last = (i == n_bytes - 1);
            cmd_err = 1'b0;
            dat_err = 1'b0;
            if (i == err_idx || (seen_err && i == drain_err_idx)) begin
                if (use_cmd) cmd_err = 1'b1; else dat_err = 1'b1;
            end
            exp_d = !seen_err && (i == err_idx || i == n_bytes - 1);
            if (i == err_idx) seen_err = 1'b1;
            // Bus width / opcode may wander mid-block without effect (R3)
            if (i > 0) begin
                op_hs200 = 1'($urandom);
                bus_width = 2'($urandom);
            end
        end
        @(negedge clk);
        check(chk_done == exp_d, {req, " final done R7"}, chk_done, exp_d);
        if (exp_d)
            check(chk_fail == exp_fail && chk_pass == !exp_fail, {req, " verdict"}, chk_fail, exp_fail);
        rx_valid = 1'b0;
        rx_last = 1'b0;
        cmd_err = 1'b0;
        dat_err = 1'b0;
        @(negedge clk);
        check(chk_done == 1'b0, "R7 done is one cycle", chk_done, 0);
        check(chk_fail == exp_fail && chk_pass == !exp_fail, "R8 verdict held", chk_fail, exp_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check(!chk_done && !chk_pass && !chk_fail, "R1 reset outputs", {chk_done, chk_pass, chk_fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!chk_done && !chk_pass && !chk_fail, "R1 after release", {chk_done, chk_pass, chk_fail}, 0);

        // Directed cases
        run_block(1'b0, 2'b01, 64, -1, -1, 1'b0, -1, 1'b0, "R2 short clean");
        run_block(1'b1, 2'b10, 128, -1, -1, 1'b0, -1, 1'b0, "R3 long clean");
        run_block(1'b1, 2'b01, 64, -1, -1, 1'b0, -1, 1'b0, "R3 hs narrow uses short");
        run_block(1'b0, 2'b10, 128, -1, -1, 1'b0, -1, 1'b0, "R3 wide non-hs long fails");
        run_block(1'b0, 2'b00, 64, -1, -1, 1'b0, -1, 1'b1, "R2 byte order swapped");
        run_block(1'b1, 2'b10, 128, 127, -1, 1'b0, -1, 1'b0, "R4 last byte wrong");
        run_block(1'b0, 2'b00, 63, -1, -1, 1'b0, -1, 1'b0, "R5 short by one");
        run_block(1'b0, 2'b00, 65, -1, -1, 1'b0, -1, 1'b0, "R5 one extra");
        run_block(1'b0, 2'b00, 64, -1, 63, 1'b1, -1, 1'b0, "R9 error with final byte");
        run_block(1'b0, 2'b00, 1, -1, 0, 1'b0, -1, 1'b0, "R9 single byte with error");
        run_block(1'b1, 2'b10, 128, -1, 10, 1'b0, 50, 1'b0, "R6 mid error then drain error");
        run_block(1'b0, 2'b01, 64, -1, -1, 1'b0, -1, 1'b0, "R6 clean after drain");

        // Idle error pulse
        @(negedge clk);
        cmd_err = 1'b1;
        @(negedge clk);
        cmd_err = 1'b0;
        check(chk_done && chk_fail && !chk_pass, "R6 idle error", {chk_done, chk_fail}, 3);
        @(negedge clk);
        check(!chk_done, "R7 idle error single pulse", chk_done, 0);
        run_block(1'b0, 2'b00, 64, -1, -1, 1'b0, -1, 1'b0, "R6 idle after idle error");

        // Random mix
        for (int b = 0; b < 60; b++) begin
            bit hs;
            logic [1:0] bw;
            int plen;
            int kind;
            int n;
            int bad;
            int err;
            int derr;
            hs = 1'($urandom);
            bw = 2'($urandom);
            if ($urandom % 2) begin hs = 1'b1; bw = 2'b10; end
            plen = (hs && bw == 2'b10) ? 128 : 64;
            kind = $urandom % 6;
            n = plen; bad = -1; err = -1; derr = -1;
            case (kind)
                2: bad = $urandom % plen;
                3: n = 1 + ($urandom % (plen - 1));
                4: n = plen + 1 + ($urandom % 5);
                5: begin
                    err = $urandom % plen;
                    if (err + 1 < plen) derr = err + 1 + ($urandom % (plen - err - 1));
                end
                default: ;
            endcase
            run_block(hs, bw, n, bad, err, 1'($urandom), derr, 1'b0, "R4 R5 R6 random");
            repeat ($urandom % 3) @(negedge clk);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule